// File: doc/BRIEF.md
# PLL Configuration Front End with Keyed Commit

This block is the register front end of a clock-multiplying PLL. Software writes the run bits (enable, connect) and the ratio fields (multiplier code, divider code) into holding registers. Those writes do nothing to the PLL until an unlock pair is written to a key register on back-to-back bus cycles. The pair is 0xAA followed by 0x55. On the second write, the holding contents are copied into shadow registers, and only the shadow registers drive the PLL.

A read-only status register shows what the PLL is really using: the shadow fields and a synchronized lock flag. The same lock flag is also driven out as an interrupt request. A clock-select output picks the PLL output only when the shadow enable and shadow connect bits are both set.

The hardware never checks lock before connecting. It also never drops the connection when lock is lost. That sequencing is left to software.

Top module: `pll_feed_ctrl`

## Requirements
- R1: After reset, both holding registers, all shadow state, the status value, clk_sel_pll_o, pll_en_o and lock_irq_o are zero.
- R2: The control holding register sits at offset 0x0. Bit 0 is enable and bit 1 is connect. A read returns those two bits, and all other bits read as zero.
- R3: The configuration holding register sits at offset 0x4. It holds the multiplier code in bits 4:0 and the divider code in bits 6:5. Bit 7 and above are dropped on write and read as zero.
- R4: A write of 0xAA to the key register (offset 0xC), followed on the very next clock by a write of 0x55, copies both holding registers to the shadow registers. The copy happens at the clock edge of the 0x55 write.
- R5: The shadow registers do not change in any of these cases: a wrong key value, the wrong order, an idle cycle between the two writes, any other access between the two writes, or holding-register writes with no key pair.
- R6: The key register reads back as zero.
- R7: The status register at offset 0x8 reads shadow multiplier in 4:0, shadow divider in 6:5, shadow enable in bit 8, shadow connect in bit 9 and the lock flag in bit 10. Bits 7 and 15:11 read as zero. The status shows shadow values, not holding values.
- R8: clk_sel_pll_o is 1 only when shadow enable and shadow connect are both 1. It is 0 for every other combination.
- R9: Connecting is allowed while the lock flag is low. A later loss of lock does not clear clk_sel_pll_o.
- R10: lock_i reaches status bit 10 and lock_irq_o through SYNC_STAGES flops (2 by default). The flag is still 0 one clock after lock_i rises and is 1 after two clocks.
- R11: pll_mult_factor_o is the shadow multiplier code plus one (1 to 32). pll_div_factor_o is 1, 2, 4 or 8 for divider codes 0 to 3.
- R12: A second 0xAA arriving while a first 0xAA is pending re-arms the detector, so an immediately following 0x55 still commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the cycle of a read access |
| lock_i | input | 1 | Raw lock indication from the PLL |
| pll_en_o | output | 1 | Shadow enable to the PLL |
| pll_mult_o | output | 5 | Shadow multiplier code |
| pll_div_o | output | 2 | Shadow divider code |
| pll_mult_factor_o | output | 6 | Decoded multiply factor |
| pll_div_factor_o | output | 4 | Decoded divide factor |
| clk_sel_pll_o | output | 1 | 1 selects the PLL clock, 0 the oscillator |
| lock_irq_o | output | 1 | Lock interrupt request |

## Verification
The assertions watch several properties on every cycle:
- the shadow registers hold steady in any cycle without a commit;
- a commit always follows an 0xAA key write on the previous clock;
- the PLL clock selection only ever rises right after a commit;
- key reads return zero, and the reserved status bits stay zero.

Some behaviour only the directed scenarios can show. These include which exact key sequences are rejected (idle gap, intruding read, reversed order, wrong value) and the re-arm on a repeated 0xAA. They also include the decoded factors at the ends of their ranges and the two-clock lock latency. Finally, they show that the connection survives a loss of lock.

// File: rtl/pll_feed_pkg.sv
package pll_feed_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned MULT_W = 5;
  localparam int unsigned DIV_W  = 2;
  localparam int unsigned KEY_W  = 8;
  localparam int unsigned MFAC_W = MULT_W + 1;
  localparam int unsigned DFAC_W = (1 << DIV_W);

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 4'hC;

  localparam logic [KEY_W-1:0] KEY_FIRST  = 8'hAA;
  localparam logic [KEY_W-1:0] KEY_SECOND = 8'h55;

  typedef struct packed {
    logic conn;
    logic en;
  } pll_ctrl_t;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [MULT_W-1:0] mult;
  } pll_cfg_t;

  typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_e;
endpackage

// File: rtl/pll_key_seq.sv
module pll_key_seq
  import pll_feed_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             commit_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d  = KEY_IDLE;
    commit_o = 1'b0;
    if (acc_i) begin
      if (key_wr_i && key_i == KEY_FIRST) begin
        state_d = KEY_ARMED;            // fresh 0xAA always (re)arms
      end else if (state_q == KEY_ARMED && key_wr_i && key_i == KEY_SECOND) begin
        commit_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_IDLE;
    else         state_q <= state_d;
  end

  // R4: a commit is always preceded by a first-key write on the prior clock
  p_commit_after_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(acc_i && key_wr_i && key_i == KEY_FIRST));
endmodule

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pll_shadow_bank.sv
module pll_shadow_bank
  import pll_feed_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  pll_ctrl_t         ctrl_i,
  input  pll_cfg_t          cfg_i,
  output pll_ctrl_t         ctrl_o,
  output pll_cfg_t          cfg_o,
  output logic              clk_sel_o,
  output logic [MFAC_W-1:0] mult_factor_o,
  output logic [DFAC_W-1:0] div_factor_o
);
  pll_ctrl_t ctrl_q;
  pll_cfg_t  cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
    end else if (commit_i) begin
      ctrl_q <= ctrl_i;
      cfg_q  <= cfg_i;
    end
  end

  assign ctrl_o        = ctrl_q;
  assign cfg_o         = cfg_q;
  // no lock qualification by design: software owns sequencing
  assign clk_sel_o     = ctrl_q.en & ctrl_q.conn;
  assign mult_factor_o = MFAC_W'(cfg_q.mult) + MFAC_W'(1);
  assign div_factor_o  = DFAC_W'(1) << cfg_q.div;

  // R5: without a commit the shadow state is frozen
  p_shadow_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable({ctrl_q, cfg_q}));

  // R8: PLL selection can only begin right after a commit
  p_sel_after_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_sel_o) |-> $past(commit_i));
endmodule

// File: rtl/pll_feed_ctrl.sv
module pll_feed_ctrl
  import pll_feed_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              lock_i,
  output logic              pll_en_o,
  output logic [MULT_W-1:0] pll_mult_o,
  output logic [DIV_W-1:0]  pll_div_o,
  output logic [MFAC_W-1:0] pll_mult_factor_o,
  output logic [DFAC_W-1:0] pll_div_factor_o,
  output logic              clk_sel_pll_o,
  output logic              lock_irq_o
);
  localparam int unsigned CFG_W  = $bits(pll_cfg_t);
  localparam int unsigned CTRL_W = $bits(pll_ctrl_t);

  pll_ctrl_t ctrl_hold_q, ctrl_sh;
  pll_cfg_t  cfg_hold_q,  cfg_sh;
  logic      wr, rd, commit, lock_flag;

  assign wr = req_i &  we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_hold_q <= '0;
      cfg_hold_q  <= '0;
    end else if (wr) begin
      if (addr_i == OFS_CTRL) ctrl_hold_q <= pll_ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (addr_i == OFS_CFG)  cfg_hold_q  <= pll_cfg_t'(wdata_i[CFG_W-1:0]);
    end
  end

  pll_key_seq u_key_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (req_i),
    .key_wr_i (wr && addr_i == OFS_KEY),
    .key_i    (wdata_i[KEY_W-1:0]),
    .commit_o (commit)
  );

  pll_shadow_bank u_shadow (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .commit_i      (commit),
    .ctrl_i        (ctrl_hold_q),
    .cfg_i         (cfg_hold_q),
    .ctrl_o        (ctrl_sh),
    .cfg_o         (cfg_sh),
    .clk_sel_o     (clk_sel_pll_o),
    .mult_factor_o (pll_mult_factor_o),
    .div_factor_o  (pll_div_factor_o)
  );

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lock_i),
    .q_o    (lock_flag)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        OFS_CTRL: rdata_o = DATA_W'(ctrl_hold_q);
        OFS_CFG:  rdata_o = DATA_W'(cfg_hold_q);
        OFS_STAT: rdata_o = {5'b0, lock_flag, ctrl_sh.conn, ctrl_sh.en, 1'b0,
                             cfg_sh.div, cfg_sh.mult};
        default:  rdata_o = '0;         // key is write-only
      endcase
    end
  end

  assign pll_en_o   = ctrl_sh.en;
  assign pll_mult_o = cfg_sh.mult;
  assign pll_div_o  = cfg_sh.div;
  assign lock_irq_o = lock_flag;

  // R6: key offset never returns data
  p_key_reads_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == OFS_KEY) |-> rdata_o == '0);

  // R7: reserved status bits stay clear
  p_stat_rsvd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == OFS_STAT) |-> (rdata_o[7] == 1'b0 && rdata_o[15:11] == '0));
endmodule

// File: tb/pll_feed_ctrl_tb_top.sv
`timescale 1ns/1ps
module pll_feed_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        lock_i = 1'b0;
  logic        pll_en_o;
  logic [4:0]  pll_mult_o;
  logic [1:0]  pll_div_o;
  logic [5:0]  pll_mult_factor_o;
  logic [3:0]  pll_div_factor_o;
  logic        clk_sel_pll_o;
  logic        lock_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pll_feed_ctrl dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic key_pair(input logic [7:0] a, input logic [7:0] b);
    wr(4'hC, {8'h0, a});
    wr(4'hC, {8'h0, b});
    idle();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(4'h8, d); chk("R1 status", d, 0);
    rd(4'h0, d); chk("R1 ctrl", d, 0);
    rd(4'h4, d); chk("R1 cfg", d, 0);
    idle();
    chk("R1 clk_sel", clk_sel_pll_o, 0);
    chk("R1 en", pll_en_o, 0);
    chk("R1 irq", lock_irq_o, 0);
  endtask

  task automatic t_holding();
    logic [15:0] d;
    wr(4'h0, 16'hFFFF);
    wr(4'h4, 16'hFFFF);
    rd(4'h0, d); chk("R2 ctrl readback", d, 16'h0003);
    rd(4'h4, d); chk("R3 cfg readback", d, 16'h007F);
    rd(4'h8, d); chk("R5 no key no shadow change", d, 0);
    idle();
    chk("R5 clk_sel held", clk_sel_pll_o, 0);
  endtask

  task automatic t_commit();
    logic [15:0] d;
    wr(4'h4, 16'h0025);                 // mult 5, div code 1
    wr(4'h0, 16'h0001);                 // enable only
    idle();
    key_pair(8'hAA, 8'h55);
    chk("R4 en", pll_en_o, 1);
    chk("R4 mult", pll_mult_o, 5);
    chk("R4 div", pll_div_o, 1);
    chk("R11 mult factor 6", pll_mult_factor_o, 6);
    chk("R11 div factor 2", pll_div_factor_o, 2);
    chk("R8 en without conn", clk_sel_pll_o, 0);
    rd(4'h8, d); chk("R7 status", d, 16'h0125);
    idle();
  endtask

  task automatic t_rejects();
    logic [15:0] d;
    wr(4'h0, 16'h0003);
    wr(4'h4, 16'h0040);
    idle();
    wr(4'hC, 16'h00AA); idle(); wr(4'hC, 16'h0055); idle();
    chk("R5 idle gap", clk_sel_pll_o, 0);
    key_pair(8'h55, 8'hAA);
    chk("R5 wrong order", clk_sel_pll_o, 0);
    key_pair(8'hAA, 8'h54);
    chk("R5 wrong value", clk_sel_pll_o, 0);
    wr(4'hC, 16'h00AA); rd(4'h0, d); wr(4'hC, 16'h0055); idle();
    chk("R5 intruding read", clk_sel_pll_o, 0);
    rd(4'h8, d); chk("R7 status shows shadow not holding", d, 16'h0125);
    idle();
  endtask

  task automatic t_rearm();
    logic [15:0] d;
    wr(4'hC, 16'h00AA); wr(4'hC, 16'h00AA); wr(4'hC, 16'h0055); idle();
    chk("R12 rearm commits", pll_div_o, 2);
    chk("R8 en and conn", clk_sel_pll_o, 1);
    chk("R9 connect while unlocked", lock_irq_o, 0);
    rd(4'h8, d); chk("R7 status connected", d, 16'h0340);
    rd(4'hC, d); chk("R6 key reads zero", d, 0);
    idle();
  endtask

  task automatic t_lock();
    logic [15:0] d;
    lock_i = 1'b1;
    @(negedge clk_i); chk("R10 one clock latency", lock_irq_o, 0);
    @(negedge clk_i); chk("R10 two clock latency", lock_irq_o, 1);
    rd(4'h8, d); chk("R10 status lock bit", d, 16'h0740);
    idle();
    lock_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R10 lock drop", lock_irq_o, 0);
    chk("R9 no auto disconnect", clk_sel_pll_o, 1);
  endtask

  task automatic t_factors();
    wr(4'h4, 16'h007F); wr(4'h0, 16'h0002); idle();
    key_pair(8'hAA, 8'h55);
    chk("R11 mult factor 32", pll_mult_factor_o, 32);
    chk("R11 div factor 8", pll_div_factor_o, 8);
    chk("R8 conn without en", clk_sel_pll_o, 0);
    wr(4'h4, 16'h0000); wr(4'h0, 16'h0000); idle();
    key_pair(8'hAA, 8'h55);
    chk("R11 mult factor 1", pll_mult_factor_o, 1);
    chk("R11 div factor 1", pll_div_factor_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_holding();
    t_commit();
    t_rejects();
    t_rearm();
    t_lock();
    t_factors();
    repeat (2) @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule